// File: doc/BRIEF.md
# Link Bring-up and Speed-Change Recovery Supervisor

This block powers up and trains a serial link on a root port, then keeps watch over training until the link comes up or the attempt is abandoned. A single request pulse starts a fixed sequence. Endpoint power is held off and then turned on. The reference clock is enabled and given time to settle. The endpoint reset is held and then released. The link speed cap is forced to first generation, and the training engine is enabled. Every delay is a cycle count set by a parameter.

Once training is enabled, the block polls the link status at a fixed interval. On each poll it reads the receive-valid flag from the PHY through a simple register request port. A speed change can stall, with training parked in receiver lock during recovery while no valid receive data arrives. When that happens, the block turns on two receiver override bits with a read-modify-write, keeps them on for a hold time, and then clears them again. If the link has not come up after a set number of polls, the block latches a failure flag together with a copy of both debug status words. The flag and the copy stay until the next start request.

Top module: `link_bringup_supervisor`

## Requirements
- R1: After reset, power_en, refclk_en, ep_rst_n, train_en, link_up, bringup_fail and phy_req are all 0, and speed_cap is 0.
- R2: A start request accepted in cycle t makes power_en rise PWR_LOW_CYC+1 cycles later. refclk_en then rises PWR_HIGH_CYC cycles after power_en. ep_rst_n rises CLK_SETTLE_CYC+RST_LOW_CYC cycles after refclk_en, and train_en rises RST_POST_CYC cycles after ep_rst_n.
- R3: speed_cap equals 1 (first-generation only) whenever train_en is high.
- R4: The link counts as up when bit 4 of dbg_link_word is 1 and bit 29 of it is 0. Once a poll sees this, link_up goes high, train_en stays high and no further PHY accesses are issued.
- R5: Each poll that finds the link down reads PHY address 0x100D. If bit 0 of the returned data (receive valid) is 1, no override access follows.
- R6: When bits [5:0] of dbg_state_word equal 0x0D and receive valid is 0, the block does the following: it reads 0x1005, writes back that value OR 0x0028, waits, reads 0x1005 again, and writes back that value AND NOT 0x0028. phy_req and its address stay stable until phy_ack.
- R7: The second read of 0x1005 is issued no sooner than RCV_HOLD_CYC cycles after the setting write is acknowledged.
- R8: A stalled-looking receive (receive valid 0) while the training state is not 0x0D triggers no override access.
- R9: Polls are spaced at least POLL_GAP_CYC cycles apart. After POLL_LIMIT reads of 0x100D without the link coming up, bringup_fail goes high and train_en goes low.
- R10: bringup_fail and the two snapshot outputs hold the debug words seen at the failing poll. They stay unchanged until a new start request, which clears bringup_fail.
- R11: The setting override write is never started if the link-up condition held when the decision to write was taken. In that case the block goes to link_up instead.
- R12: A start request that arrives while a sequence is in progress is ignored, and the timing of R2 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Pulse that starts a bring-up sequence |
| dbg_state_word | input | 32 | Debug word; bits [5:0] hold the training state |
| dbg_link_word | input | 32 | Debug word; bit 4 link up, bit 29 in training |
| phy_req | output | 1 | PHY register access request, held until phy_ack |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle acknowledge of the current access |
| phy_rdata | input | 16 | Read data, valid with phy_ack |
| power_en | output | 1 | Endpoint power enable |
| refclk_en | output | 1 | Reference clock enable |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| train_en | output | 1 | Training engine enable |
| speed_cap | output | 4 | Link speed cap field |
| link_up | output | 1 | Link came up |
| bringup_fail | output | 1 | Latched bring-up failure |
| snap_state_word | output | 32 | dbg_state_word captured at failure |
| snap_link_word | output | 32 | dbg_link_word captured at failure |

## Verification
A wrong sequencer state appears first on the enable and reset outputs, because their edge spacing after a start request moves by whole phases. A corrupted timer shows up within one phase as an interval off by its full length. Mistakes in the recovery path show up on the PHY port itself, at the next access: a wrong address, wrong override data, a missing or extra access, or a hold that is too short. A broken attempt counter shows up as failure arriving after the wrong number of 0x100D reads, or as failure that clears without a restart.

// File: rtl/lbs_pkg.sv
// Shared types and constants for the link bring-up supervisor.
// Assumes the debug word bit positions and PHY addresses below are fixed by the PHY.
package lbs_pkg;

    typedef enum logic [4:0] {
        S_IDLE     = 5'd0,
        S_PWR_LO   = 5'd1,
        S_PWR_HI   = 5'd2,
        S_CLK_SET  = 5'd3,
        S_RST_LO   = 5'd4,
        S_RST_POST = 5'd5,
        S_POLL     = 5'd6,
        S_RXV_RD   = 5'd7,
        S_OVR_RD1  = 5'd8,
        S_SET_CHK  = 5'd9,
        S_OVR_WR1  = 5'd10,
        S_HOLD     = 5'd11,
        S_OVR_RD2  = 5'd12,
        S_OVR_WR2  = 5'd13,
        S_GAP      = 5'd14,
        S_UP       = 5'd15,
        S_FAIL     = 5'd16
    } lbs_state_e;

    localparam int          LNK_UP_BIT    = 4;
    localparam int          LNK_TRAIN_BIT = 29;
    localparam logic [5:0]  STUCK_STATE   = 6'h0D;
    localparam logic [15:0] RXV_ADDR      = 16'h100D;
    localparam logic [15:0] OVR_ADDR      = 16'h1005;
    localparam logic [15:0] OVR_MASK      = 16'h0028;
    localparam logic [3:0]  GEN1_CAP      = 4'd1;

endpackage

// File: rtl/lbs_delay_timer.sv
// Down-counting phase timer. Loaded with N-1 on entry to a timed phase,
// reports zero in the last cycle of the phase. Assumes N >= 1.
module lbs_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lbs_phy_port.sv
// PHY register access master. Accepts a command level from the sequencer
// when idle, holds the request until acknowledged, returns a one-cycle done
// with captured read data. Assumes phy_ack only arrives while phy_req is high.
module lbs_phy_port #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_done,
    output logic [DW-1:0] cmd_rdata,
    output logic          phy_req,
    output logic          phy_we,
    output logic [AW-1:0] phy_addr,
    output logic [DW-1:0] phy_wdata,
    input  logic          phy_ack,
    input  logic [DW-1:0] phy_rdata
);
    typedef enum logic [1:0] {P_IDLE, P_BUSY, P_DONE} port_state_e;
    port_state_e pst_q;

    // Launch, hold and retire one register access at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q     <= P_IDLE;
            phy_req   <= 1'b0;
            phy_we    <= 1'b0;
            phy_addr  <= '0;
            phy_wdata <= '0;
            cmd_rdata <= '0;
        end else begin
            case (pst_q)
                P_IDLE: if (cmd_valid) begin
                    phy_req   <= 1'b1;
                    phy_we    <= cmd_we;
                    phy_addr  <= cmd_addr;
                    phy_wdata <= cmd_wdata;
                    pst_q     <= P_BUSY;
                end
                P_BUSY: if (phy_ack) begin
                    phy_req   <= 1'b0;
                    cmd_rdata <= phy_rdata;
                    pst_q     <= P_DONE;
                end
                default: pst_q <= P_IDLE;
            endcase
        end
    end

    assign cmd_done = (pst_q == P_DONE);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

endmodule

// File: rtl/lbs_seq_fsm.sv
// Bring-up sequencer and training supervisor. Walks the power, clock and
// endpoint-reset phases, then polls link status, runs receiver override
// recovery on a stalled speed change and latches failure after the poll limit.
// Assumes the timer and PHY port are the companion modules in this block.
module lbs_seq_fsm
    import lbs_pkg::*;
#(
    parameter int DBG_W          = 32,
    parameter int AW             = 16,
    parameter int DW             = 16,
    parameter int CNT_W          = 8,
    parameter int PWR_LOW_CYC    = 4,
    parameter int PWR_HIGH_CYC   = 4,
    parameter int CLK_SETTLE_CYC = 4,
    parameter int RST_LOW_CYC    = 4,
    parameter int RST_POST_CYC   = 4,
    parameter int POLL_GAP_CYC   = 4,
    parameter int POLL_LIMIT     = 4,
    parameter int RCV_HOLD_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [DBG_W-1:0] dbg_state_word,
    input  logic [DBG_W-1:0] dbg_link_word,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cmd_valid,
    output logic             cmd_we,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_wdata,
    input  logic             cmd_done,
    input  logic [DW-1:0]    cmd_rdata,
    output logic             power_en,
    output logic             refclk_en,
    output logic             ep_rst_n,
    output logic             train_en,
    output logic [3:0]       speed_cap,
    output logic             link_up,
    output logic             bringup_fail,
    output logic [DBG_W-1:0] snap_state_word,
    output logic [DBG_W-1:0] snap_link_word
);
    localparam int ATT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [DW-1:0] MASK = DW'(OVR_MASK);

    lbs_state_e state_q, state_d;
    logic [ATT_W-1:0] att_q;
    logic [DW-1:0]    ovr_q;
    logic             link_cond, stuck, can_start;

    assign link_cond = dbg_link_word[LNK_UP_BIT] && !dbg_link_word[LNK_TRAIN_BIT];
    assign stuck     = (dbg_state_word[5:0] == STUCK_STATE) && !cmd_rdata[0];
    assign can_start = (state_q == S_IDLE) || (state_q == S_UP) || (state_q == S_FAIL);

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE, S_UP, S_FAIL: if (start_req) state_d = S_PWR_LO;
            S_PWR_LO:   if (tmr_zero) state_d = S_PWR_HI;
            S_PWR_HI:   if (tmr_zero) state_d = S_CLK_SET;
            S_CLK_SET:  if (tmr_zero) state_d = S_RST_LO;
            S_RST_LO:   if (tmr_zero) state_d = S_RST_POST;
            S_RST_POST: if (tmr_zero) state_d = S_POLL;
            S_POLL: begin
                if (link_cond)                         state_d = S_UP;
                else if (att_q == ATT_W'(POLL_LIMIT))  state_d = S_FAIL;
                else                                   state_d = S_RXV_RD;
            end
            S_RXV_RD:  if (cmd_done) state_d = stuck ? S_OVR_RD1 : S_GAP;
            S_OVR_RD1: if (cmd_done) state_d = S_SET_CHK;
            S_SET_CHK: state_d = link_cond ? S_UP : S_OVR_WR1;
            S_OVR_WR1: if (cmd_done) state_d = S_HOLD;
            S_HOLD:    if (tmr_zero) state_d = S_OVR_RD2;
            S_OVR_RD2: if (cmd_done) state_d = S_OVR_WR2;
            S_OVR_WR2: if (cmd_done) state_d = S_GAP;
            S_GAP:     if (tmr_zero) state_d = S_POLL;
            default:   state_d = S_IDLE;
        endcase
    end

    // Timer load value for the phase being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_PWR_LO:   tmr_val = CNT_W'(PWR_LOW_CYC - 1);
            S_PWR_HI:   tmr_val = CNT_W'(PWR_HIGH_CYC - 1);
            S_CLK_SET:  tmr_val = CNT_W'(CLK_SETTLE_CYC - 1);
            S_RST_LO:   tmr_val = CNT_W'(RST_LOW_CYC - 1);
            S_RST_POST: tmr_val = CNT_W'(RST_POST_CYC - 1);
            S_HOLD:     tmr_val = CNT_W'(RCV_HOLD_CYC - 1);
            S_GAP:      tmr_val = CNT_W'(POLL_GAP_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    // PHY command for the current access phase.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = AW'(OVR_ADDR);
        cmd_wdata = '0;
        case (state_q)
            S_RXV_RD:  begin cmd_valid = 1'b1; cmd_addr = AW'(RXV_ADDR); end
            S_OVR_RD1: cmd_valid = 1'b1;
            S_OVR_RD2: cmd_valid = 1'b1;
            S_OVR_WR1: begin cmd_valid = 1'b1; cmd_we = 1'b1; cmd_wdata = ovr_q | MASK; end
            S_OVR_WR2: begin cmd_valid = 1'b1; cmd_we = 1'b1; cmd_wdata = ovr_q & ~MASK; end
            default: ;
        endcase
    end

    // Phase register, attempt count, override value, speed cap and snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= S_IDLE;
            att_q           <= '0;
            ovr_q           <= '0;
            speed_cap       <= 4'd0;
            snap_state_word <= '0;
            snap_link_word  <= '0;
        end else begin
            state_q <= state_d;
            if (can_start && start_req)
                att_q <= '0;
            else if (state_q == S_POLL && state_d == S_RXV_RD)
                att_q <= att_q + 1'b1;
            if ((state_q == S_OVR_RD1 || state_q == S_OVR_RD2) && cmd_done)
                ovr_q <= cmd_rdata;
            if (state_q == S_RST_POST)
                speed_cap <= GEN1_CAP;
            if (state_q == S_POLL && state_d == S_FAIL) begin
                snap_state_word <= dbg_state_word;
                snap_link_word  <= dbg_link_word;
            end
        end
    end

    // Moore outputs by phase order.
    assign power_en     = (state_q != S_IDLE) && (state_q != S_PWR_LO);
    assign refclk_en    = (state_q >= S_CLK_SET);
    assign ep_rst_n     = (state_q >= S_RST_POST);
    assign train_en     = (state_q >= S_POLL) && (state_q != S_FAIL);
    assign link_up      = (state_q == S_UP);
    assign bringup_fail = (state_q == S_FAIL);

    assert_att_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        att_q <= ATT_W'(POLL_LIMIT));

    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bringup_fail && !start_req) |=> bringup_fail);

    assert_ignore_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!can_start && state_q != S_PWR_LO && start_req) |=> (state_q != S_PWR_LO));

endmodule

// File: rtl/link_bringup_supervisor.sv
// Top of the link bring-up supervisor. Connects the sequencer, its phase
// timer and the PHY register access port. Delays are cycle counts.
// Assumes start_req is a single-cycle pulse and phy_ack a single-cycle reply.
module link_bringup_supervisor
    import lbs_pkg::*;
#(
    parameter int DBG_W          = 32,
    parameter int PHY_AW         = 16,
    parameter int PHY_DW         = 16,
    parameter int PWR_LOW_CYC    = 5_000_000,
    parameter int PWR_HIGH_CYC   = 5_000_000,
    parameter int CLK_SETTLE_CYC = 12_500_000,
    parameter int RST_LOW_CYC    = 5_000_000,
    parameter int RST_POST_CYC   = 5_000_000,
    parameter int POLL_GAP_CYC   = 2_500,
    parameter int POLL_LIMIT     = 2_000,
    parameter int RCV_HOLD_CYC   = 750_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DBG_W-1:0]  dbg_state_word,
    input  logic [DBG_W-1:0]  dbg_link_word,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata,
    output logic              power_en,
    output logic              refclk_en,
    output logic              ep_rst_n,
    output logic              train_en,
    output logic [3:0]        speed_cap,
    output logic              link_up,
    output logic              bringup_fail,
    output logic [DBG_W-1:0]  snap_state_word,
    output logic [DBG_W-1:0]  snap_link_word
);
    localparam int MAX_A   = (PWR_LOW_CYC > PWR_HIGH_CYC) ? PWR_LOW_CYC : PWR_HIGH_CYC;
    localparam int MAX_B   = (CLK_SETTLE_CYC > RST_LOW_CYC) ? CLK_SETTLE_CYC : RST_LOW_CYC;
    localparam int MAX_C   = (RST_POST_CYC > POLL_GAP_CYC) ? RST_POST_CYC : POLL_GAP_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CD  = (MAX_C > RCV_HOLD_CYC) ? MAX_C : RCV_HOLD_CYC;
    localparam int MAX_DLY = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              cmd_valid, cmd_we, cmd_done;
    logic [PHY_AW-1:0] cmd_addr;
    logic [PHY_DW-1:0] cmd_wdata, cmd_rdata;
    logic              link_cond;

    assign link_cond = dbg_link_word[LNK_UP_BIT] && !dbg_link_word[LNK_TRAIN_BIT];

    lbs_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    lbs_phy_port #(.AW(PHY_AW), .DW(PHY_DW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    lbs_seq_fsm #(
        .DBG_W(DBG_W), .AW(PHY_AW), .DW(PHY_DW), .CNT_W(CNT_W),
        .PWR_LOW_CYC(PWR_LOW_CYC), .PWR_HIGH_CYC(PWR_HIGH_CYC),
        .CLK_SETTLE_CYC(CLK_SETTLE_CYC), .RST_LOW_CYC(RST_LOW_CYC),
        .RST_POST_CYC(RST_POST_CYC), .POLL_GAP_CYC(POLL_GAP_CYC),
        .POLL_LIMIT(POLL_LIMIT), .RCV_HOLD_CYC(RCV_HOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .dbg_state_word(dbg_state_word), .dbg_link_word(dbg_link_word),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .power_en(power_en), .refclk_en(refclk_en), .ep_rst_n(ep_rst_n), .train_en(train_en),
        .speed_cap(speed_cap), .link_up(link_up), .bringup_fail(bringup_fail),
        .snap_state_word(snap_state_word), .snap_link_word(snap_link_word)
    );

    assert_cap_gen1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_en |-> (speed_cap == GEN1_CAP));

    assert_train_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en) |-> (ep_rst_n && refclk_en && power_en));

    assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && bringup_fail));

    assert_no_set_when_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we && !$past(phy_req) && ((phy_wdata & PHY_DW'(OVR_MASK)) == PHY_DW'(OVR_MASK)))
        |-> !$past(link_cond, 2));

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bringup_fail && !start_req) |=> ($stable(snap_state_word) && $stable(snap_link_word)));

endmodule

// File: tb/link_bringup_supervisor_tb_top.sv
module link_bringup_supervisor_tb_top;

    localparam int PWR_LOW    = 5;
    localparam int PWR_HIGH   = 6;
    localparam int CLK_SETTLE = 7;
    localparam int RST_LOW    = 4;
    localparam int RST_POST   = 3;
    localparam int POLL_GAP   = 5;
    localparam int POLL_LIM   = 6;
    localparam int RCV_HOLD   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [31:0] dbg_state_word = '0;
    logic [31:0] link_word_drv = '0;
    logic [31:0] dbg_link_word;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        power_en, refclk_en, ep_rst_n, train_en, link_up, bringup_fail;
    logic [3:0]  speed_cap;
    logic [31:0] snap_state_word, snap_link_word;

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [15:0] data;
    } tr_t;
    tr_t exp_q[$];

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [15:0] reg_rxv = 16'h0001, reg_ovr = 16'h0104;
    int ovr_reads = 0, link_after_ovr = 0;
    int rxv_reads = 0, last_rxv = -1;
    bit gap_check = 1'b0;
    int t_start = 0, t_pwr = 0, t_clk = 0, t_rst = 0, t_trn = 0, t_set = -1;
    bit start_seen = 1'b0;
    logic p_pwr = 1'b0, p_clk = 1'b0, p_rst = 1'b0, p_trn = 1'b0;
    int wcnt = 0;

    assign dbg_link_word = (link_after_ovr != 0 && ovr_reads >= link_after_ovr) ? 32'h0000_0010 : link_word_drv;

    always #2 clk = ~clk;

    link_bringup_supervisor #(
        .PWR_LOW_CYC(PWR_LOW), .PWR_HIGH_CYC(PWR_HIGH), .CLK_SETTLE_CYC(CLK_SETTLE),
        .RST_LOW_CYC(RST_LOW), .RST_POST_CYC(RST_POST), .POLL_GAP_CYC(POLL_GAP),
        .POLL_LIMIT(POLL_LIM), .RCV_HOLD_CYC(RCV_HOLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .dbg_state_word(dbg_state_word), .dbg_link_word(dbg_link_word),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .power_en(power_en), .refclk_en(refclk_en), .ep_rst_n(ep_rst_n), .train_en(train_en),
        .speed_cap(speed_cap), .link_up(link_up), .bringup_fail(bringup_fail),
        .snap_state_word(snap_state_word), .snap_link_word(snap_link_word)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    endtask

    // Monitor and PHY model: edge timing, scoreboard compare, register responses.
    always @(negedge clk) begin
        tr_t e;
        cyc++;
        if (start_req && !start_seen) begin t_start = cyc; start_seen = 1'b1; end
        if (power_en && !p_pwr)   t_pwr = cyc;
        if (refclk_en && !p_clk)  t_clk = cyc;
        if (ep_rst_n && !p_rst)   t_rst = cyc;
        if (train_en && !p_trn) begin
            t_trn = cyc;
            check(speed_cap == 4'd1, "R3 speed cap at training enable", speed_cap, 1);
        end
        p_pwr = power_en; p_clk = refclk_en; p_rst = ep_rst_n; p_trn = train_en;
        if (phy_ack) begin
            phy_ack = 1'b0;
        end else if (phy_req) begin
            wcnt++;
            if (wcnt == 2) begin
                wcnt = 0;
                phy_ack = 1'b1;
                phy_rdata = (phy_addr == 16'h100D) ? reg_rxv : reg_ovr;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8/R11 unexpected PHY access", {phy_we, phy_addr}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.we == phy_we && e.addr == phy_addr && (!e.we || e.data == phy_wdata),
                          "R6 PHY access", {phy_we, phy_addr, phy_wdata}, {e.we, e.addr, e.data});
                end
                if (phy_we && phy_addr == 16'h1005) begin
                    reg_ovr = phy_wdata;
                    if ((phy_wdata & 16'h0028) == 16'h0028) t_set = cyc;
                end
                if (!phy_we && phy_addr == 16'h1005) begin
                    ovr_reads++;
                    if (t_set >= 0) begin
                        check(cyc - t_set >= RCV_HOLD + 1 && cyc - t_set <= RCV_HOLD + 8,
                              "R7 override hold", cyc - t_set, RCV_HOLD + 1);
                        t_set = -1;
                    end
                end
                if (!phy_we && phy_addr == 16'h100D) begin
                    rxv_reads++;
                    if (gap_check && last_rxv >= 0)
                        check(cyc - last_rxv >= POLL_GAP + 1, "R9 poll spacing", cyc - last_rxv, POLL_GAP + 1);
                    last_rxv = cyc;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(input bit we, input logic [15:0] addr, input logic [15:0] data);
        tr_t t;
        t.we = we; t.addr = addr; t.data = data;
        exp_q.push_back(t);
    endtask

    task automatic start();
        start_seen = 1'b0;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (link_up || bringup_fail) break;
            tick();
        end
    endtask

    task automatic wait_q_empty();
        for (int i = 0; i < 2000; i++) begin
            if (exp_q.size() == 0) break;
            tick();
        end
    endtask

    task automatic check_timing(input string tag);
        check(t_pwr - t_start == PWR_LOW + 1, {tag, " R2 power delay"}, t_pwr - t_start, PWR_LOW + 1);
        check(t_clk - t_pwr == PWR_HIGH, {tag, " R2 clock delay"}, t_clk - t_pwr, PWR_HIGH);
        check(t_rst - t_clk == CLK_SETTLE + RST_LOW, {tag, " R2 reset release"}, t_rst - t_clk, CLK_SETTLE + RST_LOW);
        check(t_trn - t_rst == RST_POST, {tag, " R2 training enable"}, t_trn - t_rst, RST_POST);
    endtask

    initial begin
        repeat (3) tick();
        check({power_en, refclk_en, ep_rst_n, train_en, link_up, bringup_fail, phy_req} == 7'b0,
              "R1 reset outputs", {power_en, refclk_en, ep_rst_n, train_en, link_up, bringup_fail, phy_req}, 0);
        check(speed_cap == 4'd0, "R1 reset speed cap", speed_cap, 0);
        rst_n = 1'b1;
        tick();

        // Scenario A: link stays in training, receive valid set; poll limit reached.
        dbg_state_word = 32'h0000_0011;
        link_word_drv  = 32'h2000_0010;
        reg_rxv = 16'h0001;
        gap_check = 1'b1;
        for (int i = 0; i < POLL_LIM; i++) push(1'b0, 16'h100D, 16'h0);
        start();
        wait_done();
        gap_check = 1'b0;
        check_timing("A");
        check(bringup_fail == 1'b1 && link_up == 1'b0, "R9 fail after limit", {bringup_fail, link_up}, 2'b10);
        check(rxv_reads == POLL_LIM, "R9 reads before fail", rxv_reads, POLL_LIM);
        check(train_en == 1'b0, "R9 training off at fail", train_en, 0);
        check(snap_link_word == 32'h2000_0010, "R10 link snapshot", snap_link_word, 32'h2000_0010);
        check(snap_state_word == 32'h0000_0011, "R10 state snapshot", snap_state_word, 32'h11);
        check(reg_ovr == 16'h0104, "R5 no override with receive valid", reg_ovr, 16'h0104);
        dbg_state_word = 32'h0000_0022;
        link_word_drv  = 32'h0000_0000;
        repeat (20) tick();
        check(bringup_fail == 1'b1, "R10 fail held", bringup_fail, 1);
        check(snap_state_word == 32'h0000_0011 && snap_link_word == 32'h2000_0010,
              "R10 snapshot held", snap_state_word, 32'h11);

        // Scenario B: stalled speed change, one recovery pulse then link up.
        dbg_state_word = 32'h0000_000D;
        reg_rxv = 16'h0000;
        reg_ovr = 16'h0104;
        push(1'b0, 16'h100D, 16'h0);
        push(1'b0, 16'h1005, 16'h0);
        push(1'b1, 16'h1005, 16'h012C);
        push(1'b0, 16'h1005, 16'h0);
        push(1'b1, 16'h1005, 16'h0104);
        start();
        tick();
        check(bringup_fail == 1'b0, "R10 fail cleared by start", bringup_fail, 0);
        wait_q_empty();
        link_word_drv = 32'h0000_0010;
        wait_done();
        check(link_up == 1'b1 && train_en == 1'b1, "R4 link up after recovery", {link_up, train_en}, 2'b11);
        check(reg_ovr == 16'h0104, "R6 override bits cleared", reg_ovr, 16'h0104);
        check(ovr_reads == 2, "R6 two override reads", ovr_reads, 2);

        // Scenario C: receive invalid but state not receiver lock; extra start ignored.
        link_word_drv  = 32'h0000_0000;
        dbg_state_word = 32'h0000_000C;
        push(1'b0, 16'h100D, 16'h0);
        push(1'b0, 16'h100D, 16'h0);
        start();
        repeat (PWR_LOW + 3) tick();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        wait_q_empty();
        link_word_drv = 32'h0000_0010;
        wait_done();
        check_timing("C R12");
        check(link_up == 1'b1, "R4 link up detected", link_up, 1);
        repeat (20) tick();
        check(exp_q.size() == 0 && reg_ovr == 16'h0104, "R8 no override off receiver lock", reg_ovr, 16'h0104);

        // Scenario D: link comes up while the override value is being read.
        link_word_drv  = 32'h0000_0000;
        dbg_state_word = 32'h0000_000D;
        ovr_reads = 0;
        link_after_ovr = 1;
        push(1'b0, 16'h100D, 16'h0);
        push(1'b0, 16'h1005, 16'h0);
        start();
        wait_done();
        check(link_up == 1'b1, "R11 link up instead of set write", link_up, 1);
        repeat (30) tick();
        check(reg_ovr == 16'h0104, "R11 no set write while link up", reg_ovr, 16'h0104);
        check(exp_q.size() == 0, "R11 expected accesses consumed", exp_q.size(), 0);

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        report();
        $finish;
    end

endmodule